// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block connects two W-bit buses, A and B, through a pair of storage registers. Each direction has its own capture strobe, its own drive enable and its own select. The select chooses whether the far bus is driven with the live value of the near bus or with the value held in the near register. The block has no tri-state pins. Each bus is modelled as an external driver (value plus enable), an internal driver (value plus enable) and a resolved line value that is computed inside the block.

All logic runs on one system clock. The two capture strobes are sampled on that clock, and a register loads on a 0-to-1 change of its strobe. Capture does not depend on the selects or the enables. A bus that nothing drives keeps its last resolved value. This holder also covers the loop that forms when both directions forward live data. The loop keeps both buses at the values they had before.

Top module: `reg_bus_xcvr`

## Requirements
- R1: After synchronous active-high reset, both storage registers and both bus holders are zero, so an undriven bus reads 0.
- R2: `a_store` loads the resolved A line in the cycle where `stb_ab` is 1 and was 0 at the previous clock sample. In any other cycle it keeps its value. Capture happens whatever the selects and enables are.
- R3: `b_store` loads the resolved B line on a 0-to-1 change of `stb_ba`, under the same rules as R2.
- R4: When a port's external enable is 1, that port's resolved line equals the external input value.
- R5: `drv_ab` is active high and sets `b_drive_en`. `drv_ba_n` is active low and sets `a_drive_en`. With `drv_ab`=0 and `drv_ba_n`=1, both ports are isolated.
- R6: `b_drive` is the live A line when `use_reg_ab`=0 and `a_store` when `use_reg_ab`=1. If B is driven internally and not externally, the B line takes that value.
- R7: `a_drive` is the live B line when `use_reg_ba`=0 and `b_store` when `use_reg_ba`=1. If A is driven internally and not externally, the A line takes that value.
- R8: A line that is driven neither externally nor internally keeps its value from the previous cycle.
- R9: When both directions are enabled and set to live, and neither bus is driven externally, both lines keep their previous values.
- R10: `a_clash` is 1 exactly when `a_pin_oe` and `a_drive_en` are both 1. `b_clash` is 1 exactly when `b_pin_oe` and `b_drive_en` are both 1. The external value still wins.
- R11: With A driven externally, B forwarding live A, and both strobes rising together, both registers load the A value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| a_pin_in | input | W | Value driven onto A from outside |
| a_pin_oe | input | 1 | Outside driver on A is active |
| b_pin_in | input | W | Value driven onto B from outside |
| b_pin_oe | input | 1 | Outside driver on B is active |
| stb_ab | input | 1 | Capture strobe for the A-side register |
| stb_ba | input | 1 | Capture strobe for the B-side register |
| use_reg_ab | input | 1 | 1: B is fed from a_store; 0: B is fed from the live A line |
| use_reg_ba | input | 1 | 1: A is fed from b_store; 0: A is fed from the live B line |
| drv_ab | input | 1 | Drive B, active high |
| drv_ba_n | input | 1 | Drive A, active low |
| a_drive | output | W | Value the block drives toward A |
| a_drive_en | output | 1 | Block drives A |
| b_drive | output | W | Value the block drives toward B |
| b_drive_en | output | 1 | Block drives B |
| a_line | output | W | Resolved A bus value |
| b_line | output | W | Resolved B bus value |
| a_store | output | W | A-side register |
| b_store | output | W | B-side register |
| a_clash | output | 1 | External and internal drivers both active on A |
| b_clash | output | 1 | External and internal drivers both active on B |

## Verification
The assertions assume that every input changes only between clock edges and that reset is held from time zero, so the holders and strobe history have a defined value before any property is checked. They also assume that a strobe sampled high in the first cycle after reset counts as a rising edge. The bench drives all inputs on the falling edge and keeps the strobes low during reset. Random stimulus covers every mix of enables, selects and strobes, including clashes. Directed sequences set up the isolation, live-loop and dual-store cases on purpose.

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] a_pin_in,
  input  logic         a_pin_oe,
  input  logic [W-1:0] b_pin_in,
  input  logic         b_pin_oe,
  input  logic         stb_ab,
  input  logic         stb_ba,
  input  logic         use_reg_ab,
  input  logic         use_reg_ba,
  input  logic         drv_ab,
  input  logic         drv_ba_n,
  output logic [W-1:0] a_drive,
  output logic         a_drive_en,
  output logic [W-1:0] b_drive,
  output logic         b_drive_en,
  output logic [W-1:0] a_line,
  output logic [W-1:0] b_line,
  output logic [W-1:0] a_store,
  output logic [W-1:0] b_store,
  output logic         a_clash,
  output logic         b_clash
);

  logic [W-1:0] a_hold, b_hold, a_fixed, b_fixed;
  logic stb_ab_q, stb_ba_q, a_live, b_live;

  assign a_drive_en = ~drv_ba_n;
  assign b_drive_en = drv_ab;

  assign a_live = a_drive_en & ~use_reg_ba & ~a_pin_oe;
  assign b_live = b_drive_en & ~use_reg_ab & ~b_pin_oe;

  assign a_fixed = a_pin_oe ? a_pin_in : (a_drive_en & use_reg_ba) ? b_store : a_hold;
  assign b_fixed = b_pin_oe ? b_pin_in : (b_drive_en & use_reg_ab) ? a_store : b_hold;

  assign a_line = a_live ? (b_live ? a_hold : b_fixed) : a_fixed;
  assign b_line = b_live ? (a_live ? b_hold : a_fixed) : b_fixed;

  assign a_drive = use_reg_ba ? b_store : b_line;
  assign b_drive = use_reg_ab ? a_store : a_line;

  assign a_clash = a_pin_oe & a_drive_en;
  assign b_clash = b_pin_oe & b_drive_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      a_store  <= '0;
      b_store  <= '0;
      a_hold   <= '0;
      b_hold   <= '0;
      stb_ab_q <= 1'b0;
      stb_ba_q <= 1'b0;
    end else begin
      a_hold   <= a_line;
      b_hold   <= b_line;
      stb_ab_q <= stb_ab;
      stb_ba_q <= stb_ba;
      if (stb_ab && !stb_ab_q) a_store <= a_line;
      if (stb_ba && !stb_ba_q) b_store <= b_line;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (a_store == '0 && b_store == '0));

  // R2
  a_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_ab && !stb_ab_q) |=> a_store == $past(a_line));

  // R2
  a_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (!stb_ab || stb_ab_q) |=> $stable(a_store));

  // R3
  b_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (stb_ba && !stb_ba_q) |=> b_store == $past(b_line));

  // R4
  ext_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (a_pin_oe |-> a_line == a_pin_in) and (b_pin_oe |-> b_line == b_pin_in));

  // R6
  b_from_reg_chk: assert property (@(posedge clk) disable iff (rst)
    (b_drive_en && use_reg_ab && !b_pin_oe) |-> b_line == a_store);

  // R8
  a_float_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!a_drive_en && !a_pin_oe && !$past(rst)) |-> a_line == $past(a_line));

  // R9
  loop_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (a_drive_en && b_drive_en && !use_reg_ab && !use_reg_ba &&
     !a_pin_oe && !b_pin_oe && !$past(rst))
    |-> (a_line == $past(a_line) && b_line == $past(b_line)));

endmodule

// File: tb/tb_reg_bus_xcvr.sv
module tb_reg_bus_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst;
  logic [W-1:0] a_pin_in, b_pin_in;
  logic a_pin_oe, b_pin_oe, stb_ab, stb_ba, use_reg_ab, use_reg_ba, drv_ab, drv_ba_n;
  logic [W-1:0] a_drive, b_drive, a_line, b_line, a_store, b_store;
  logic a_drive_en, b_drive_en, a_clash, b_clash;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic [W-1:0] m_ra, m_rb, m_ha, m_hb;
  logic m_pa, m_pb;

  always #5 clk = ~clk;

  reg_bus_xcvr #(.W(W)) dut (
    .clk(clk), .rst(rst),
    .a_pin_in(a_pin_in), .a_pin_oe(a_pin_oe),
    .b_pin_in(b_pin_in), .b_pin_oe(b_pin_oe),
    .stb_ab(stb_ab), .stb_ba(stb_ba),
    .use_reg_ab(use_reg_ab), .use_reg_ba(use_reg_ba),
    .drv_ab(drv_ab), .drv_ba_n(drv_ba_n),
    .a_drive(a_drive), .a_drive_en(a_drive_en),
    .b_drive(b_drive), .b_drive_en(b_drive_en),
    .a_line(a_line), .b_line(b_line),
    .a_store(a_store), .b_store(b_store),
    .a_clash(a_clash), .b_clash(b_clash)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [2*W-1:0] expect_lines();
    logic a_en, b_en, a_known, b_known;
    logic [W-1:0] av, bv, ea, eb;
    a_en = !drv_ba_n;
    b_en = drv_ab;
    a_known = a_pin_oe || (a_en && use_reg_ba) || !a_en;
    b_known = b_pin_oe || (b_en && use_reg_ab) || !b_en;
    av = a_pin_oe ? a_pin_in : (a_en && use_reg_ba) ? m_rb : m_ha;
    bv = b_pin_oe ? b_pin_in : (b_en && use_reg_ab) ? m_ra : m_hb;
    ea = a_known ? av : (b_known ? bv : m_ha);
    eb = b_known ? bv : (a_known ? av : m_hb);
    return {ea, eb};
  endfunction

  function automatic string line_tag(input logic ext, input logic en, input logic sel,
                                     input logic far_live, input string rel);
    if (ext) return "R4";
    if (!en) return "R8";
    if (!sel && far_live) return "R9";
    return rel;
  endfunction

  task automatic step(input string reg_tag);
    logic [2*W-1:0] e;
    logic a_far_live, b_far_live;
    #2;
    e = expect_lines();
    b_far_live = drv_ab && !use_reg_ab && !b_pin_oe;
    a_far_live = !drv_ba_n && !use_reg_ba && !a_pin_oe;
    chk(line_tag(a_pin_oe, !drv_ba_n, use_reg_ba, b_far_live, "R7"), a_line, e[2*W-1:W]);
    chk(line_tag(b_pin_oe, drv_ab, use_reg_ab, a_far_live, "R6"), b_line, e[W-1:0]);
    chk("R6", b_drive, use_reg_ab ? m_ra : e[2*W-1:W]);
    chk("R7", a_drive, use_reg_ba ? m_rb : e[W-1:0]);
    chk("R5", {30'd0, a_drive_en, b_drive_en}, {30'd0, !drv_ba_n, drv_ab});
    chk("R10", {30'd0, a_clash, b_clash},
        {30'd0, a_pin_oe && !drv_ba_n, b_pin_oe && drv_ab});
    chk(reg_tag, {a_store, b_store}, {m_ra, m_rb});
    @(posedge clk);
    if (stb_ab && !m_pa) m_ra = e[2*W-1:W];
    if (stb_ba && !m_pb) m_rb = e[W-1:0];
    m_pa = stb_ab;
    m_pb = stb_ba;
    m_ha = e[2*W-1:W];
    m_hb = e[W-1:0];
    @(negedge clk);
  endtask

  task automatic drive(input logic [W-1:0] ai, input logic ao, input logic [W-1:0] bi,
                       input logic bo, input logic sa, input logic sb, input logic ua,
                       input logic ub, input logic dab, input logic dban);
    a_pin_in = ai; a_pin_oe = ao; b_pin_in = bi; b_pin_oe = bo;
    stb_ab = sa; stb_ba = sb; use_reg_ab = ua; use_reg_ba = ub;
    drv_ab = dab; drv_ba_n = dban;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst = 1'b1;
    drive(8'h5A, 1'b1, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    m_ra = '0; m_rb = '0; m_ha = '0; m_hb = '0; m_pa = 1'b0; m_pb = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    drive(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    // R1: isolated after reset, lines and registers read zero
    step("R1");

    // R11: A external, B fed live from A, both strobes rise together
    drive(8'hA7, 1'b1, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R11");
    drive(8'hA7, 1'b1, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    step("R11");
    step("R11");
    chk("R11", {a_store, b_store}, {8'hA7, 8'hA7});

    // R8: isolation keeps last values, strobes held high capture nothing
    drive(8'h00, 1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R2");
    step("R3");
    chk("R8", {a_line, b_line}, {8'hA7, 8'hA7});

    // R9: set up distinct values, then close the live loop
    drive(8'h11, 1'b1, 8'h22, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    step("R3");
    drive(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step("R3");
    step("R3");
    chk("R9", {a_line, b_line}, {8'h11, 8'h22});

    // R6/R7 stored mode, plus R10 clash on both ports
    drive(8'h3C, 1'b1, 8'h96, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    step("R2");
    chk("R10", {30'd0, a_clash, b_clash}, 32'd3);
    drive(8'h00, 1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
    step("R2");
    chk("R6", b_line, {24'd0, 8'hA7});

    for (int i = 0; i < 3000; i++) begin
      logic [31:0] r;
      r = $urandom;
      drive(r[7:0], r[8] & r[9], r[17:10], r[18] & r[19],
            r[20], r[21], r[22], r[23], r[24], r[25]);
      step(r[26] ? "R2" : "R3");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule